// File: doc/BRIEF.md
# Programmable Trigger Menu Logic

This block makes the accept decision for each bunch crossing, one crossing per clock. It takes a vector of packed 3-bit multiplicity counts. Each count is decoded through its own small programmable lookup table into a group of condition bits. Together these groups form the condition vector.

Every trigger item compares the whole condition vector against its own required pattern, limited to the bits set in its care mask. Any item can therefore depend on any condition. An item that matches then passes three stages in order:

- a veto mask;
- a per-item prescale down-counter;
- a priority encoder that names the lowest-numbered surviving item.

The overall accept is raised when any item survives. All tables are loaded at run time through a simple write port. Writes are honoured only while the configuration-enable input is high, so a menu change never needs the logic rebuilt.

Top module: `trig_menu`

## Requirements
- R1: After synchronous reset, all required patterns, care masks and veto bits are zero, every prescale value is 1 with its counter at 0, and the pipeline is empty. `item_pass`, `accept`, `first_valid` and `first_index` are therefore all 0.
- R2: Field f sits in `trig_in[3f+2:3f]`. It selects entry `count` of table f, and that entry drives conditions `[f*COND_PER_FIELD +: COND_PER_FIELD]`. After reset, bit k of each entry is 1 exactly when count > k.
- R3: Item i matches when `(cond & care[i]) == (req[i] & care[i])` and `care[i]` is non-zero.
- R4: An item whose care mask is all zero never matches, whatever its required pattern holds.
- R5: A matching item whose veto bit is 1 is blocked, and its prescale counter does not move.
- R6: The prescale stage works as follows for a non-vetoed match on an item with prescale value N:
  - N = 0: the item is blocked and its counter does not change.
  - N > 0, counter at 0: the item passes and the counter reloads to N-1.
  - N > 0, counter not at 0: the counter decrements and the item does not pass.

  A prescale write loads the counter with N-1, or with 0 when N is 0. That load wins over a decrement or reload in the same cycle.
- R7: `first_index` is the lowest-numbered passing item, written as 8 bits. `first_valid` and `accept` are 1 exactly when any item passes.
- R8: The crossing presented before clock edge k appears on the outputs after edge k+2, a fixed three-register latency.
- R9: A write is applied only in a cycle where both `cfg_en` and `cfg_we` are 1. The table is chosen by `cfg_sel`:
  - 0: lookup table, with field in `cfg_addr[7:3]` and count in `cfg_addr[2:0]`;
  - 1: required pattern of item `cfg_addr`;
  - 2: care mask of item `cfg_addr`;
  - 3: veto vector, with bit i for item i and the address ignored;
  - 4: prescale value of item `cfg_addr`, in the low PS_W bits.

  Out-of-range addresses are ignored. A write takes effect from the next clock edge.
- R10: A rewritten lookup-table entry changes the conditions decoded for that field and count, and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 3*NUM_FIELDS | Packed multiplicity counts, one 3-bit field each |
| cfg_en | input | 1 | Marks crossings in which configuration may change |
| cfg_we | input | 1 | Write strobe |
| cfg_sel | input | 3 | Table select |
| cfg_addr | input | 8 | Table address |
| cfg_wdata | input | CFG_W | Write data |
| item_pass | output | NUM_ITEMS | Items surviving mask, prescale and match |
| accept | output | 1 | OR of all surviving items |
| first_valid | output | 1 | `first_index` is meaningful |
| first_index | output | 8 | Lowest-numbered surviving item |

## Verification
A wrong table entry or a wrong match shows up on `item_pass` three edges after the crossing that exposes it. It may stay hidden until an input pattern reaches that entry.

A prescale counter that is off by one stays silent until its item's next match. At that point the pass lands one match early or late. The fault then repeats at every period after it, so prescaled items are driven through several full periods.

A priority fault only appears when two or more items pass in the same crossing. The stimulus therefore stacks overlapping items and mixes configuration writes into live traffic.

// File: rtl/tmenu_pkg.sv
package tmenu_pkg;

  typedef enum logic [2:0] {
    SEL_LUT      = 3'd0,
    SEL_REQ      = 3'd1,
    SEL_CARE     = 3'd2,
    SEL_VETO     = 3'd3,
    SEL_PRESCALE = 3'd4
  } cfg_sel_e;

  localparam int unsigned CNT_W   = 3;
  localparam int unsigned LUT_D   = 1 << CNT_W;
  localparam int unsigned INDEX_W = 8;

  // Default threshold content: bit k set when the count exceeds k.
  function automatic logic thr_bit(input int unsigned count, input int unsigned k);
    return count > k;
  endfunction

endpackage

// File: rtl/tmenu_cfg.sv
module tmenu_cfg
  import tmenu_pkg::*;
#(
  parameter int unsigned NUM_FIELDS     = 4,
  parameter int unsigned COND_PER_FIELD = 4,
  parameter int unsigned NUM_ITEMS      = 16,
  parameter int unsigned PS_W           = 8,
  parameter int unsigned CFG_W          = 16,
  localparam int unsigned NC            = NUM_FIELDS * COND_PER_FIELD
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        cfg_en,
  input  logic                                        cfg_we,
  input  logic [2:0]                                  cfg_sel,
  input  logic [7:0]                                  cfg_addr,
  input  logic [CFG_W-1:0]                            cfg_wdata,
  output logic [NUM_FIELDS-1:0][LUT_D-1:0][COND_PER_FIELD-1:0] lut,
  output logic [NUM_ITEMS-1:0][NC-1:0]                req,
  output logic [NUM_ITEMS-1:0][NC-1:0]                care,
  output logic [NUM_ITEMS-1:0]                        veto,
  output logic [NUM_ITEMS-1:0][PS_W-1:0]              ps,
  output logic [NUM_ITEMS-1:0]                        ps_load,
  output logic [PS_W-1:0]                             ps_wval
);

  logic wr_fire;
  assign wr_fire = cfg_en & cfg_we;
  assign ps_wval = cfg_wdata[PS_W-1:0];

  always_comb begin
    for (int i = 0; i < NUM_ITEMS; i++)
      ps_load[i] = wr_fire && (cfg_sel == SEL_PRESCALE) && (cfg_addr == 8'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NUM_FIELDS; f++)
        for (int c = 0; c < LUT_D; c++)
          for (int k = 0; k < COND_PER_FIELD; k++)
            lut[f][c][k] <= thr_bit(c, k);
      req  <= '0;
      care <= '0;
      veto <= '0;
      for (int i = 0; i < NUM_ITEMS; i++) ps[i] <= PS_W'(1);
    end else if (wr_fire) begin
      case (cfg_sel)
        SEL_LUT: begin
          for (int f = 0; f < NUM_FIELDS; f++)
            if (cfg_addr[7:3] == 5'(f))
              lut[f][cfg_addr[2:0]] <= cfg_wdata[COND_PER_FIELD-1:0];
        end
        SEL_REQ: begin
          for (int i = 0; i < NUM_ITEMS; i++)
            if (cfg_addr == 8'(i)) req[i] <= cfg_wdata[NC-1:0];
        end
        SEL_CARE: begin
          for (int i = 0; i < NUM_ITEMS; i++)
            if (cfg_addr == 8'(i)) care[i] <= cfg_wdata[NC-1:0];
        end
        SEL_VETO: veto <= cfg_wdata[NUM_ITEMS-1:0];
        SEL_PRESCALE: begin
          for (int i = 0; i < NUM_ITEMS; i++)
            if (ps_load[i]) ps[i] <= cfg_wdata[PS_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // R9: without an accepted write, no table changes on the next edge.
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> ($stable(lut) && $stable(req) && $stable(care) && $stable(veto) && $stable(ps)));

endmodule

// File: rtl/tmenu_decode.sv
module tmenu_decode
  import tmenu_pkg::*;
#(
  parameter int unsigned NUM_FIELDS     = 4,
  parameter int unsigned COND_PER_FIELD = 4,
  localparam int unsigned NC            = NUM_FIELDS * COND_PER_FIELD,
  localparam int unsigned TW            = NUM_FIELDS * CNT_W
) (
  input  logic                                                 clk,
  input  logic                                                 rst,
  input  logic [TW-1:0]                                        trig_in,
  input  logic [NUM_FIELDS-1:0][LUT_D-1:0][COND_PER_FIELD-1:0] lut,
  output logic [NC-1:0]                                        cond_q
);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [CNT_W-1:0] count;
    assign count = trig_in[f*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (rst) cond_q[f*COND_PER_FIELD +: COND_PER_FIELD] <= '0;
      else     cond_q[f*COND_PER_FIELD +: COND_PER_FIELD] <= lut[f][count];
    end
  end

endmodule

// File: rtl/tmenu_match.sv
module tmenu_match #(
  parameter int unsigned NC        = 16,
  parameter int unsigned NUM_ITEMS = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NC-1:0]                cond_q,
  input  logic [NUM_ITEMS-1:0][NC-1:0] req,
  input  logic [NUM_ITEMS-1:0][NC-1:0] care,
  output logic [NUM_ITEMS-1:0]         match_q
);

  function automatic logic item_hit(input logic [NC-1:0] c, input logic [NC-1:0] r,
                                    input logic [NC-1:0] m);
    return (m != '0) && (((c ^ r) & m) == '0);
  endfunction

  for (genvar i = 0; i < NUM_ITEMS; i++) begin : g_item
    always_ff @(posedge clk) begin
      if (rst) match_q[i] <= 1'b0;
      else     match_q[i] <= item_hit(cond_q, req[i], care[i]);
    end

    // R4: an all-zero care mask never yields a match.
    assert_empty_care_R4: assert property (@(posedge clk) disable iff (rst)
      (care[i] == '0) |=> !match_q[i]);
  end

endmodule

// File: rtl/tmenu_select.sv
module tmenu_select
  import tmenu_pkg::*;
#(
  parameter int unsigned NUM_ITEMS = 16,
  parameter int unsigned PS_W      = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_ITEMS-1:0]           match_q,
  input  logic [NUM_ITEMS-1:0]           veto,
  input  logic [NUM_ITEMS-1:0][PS_W-1:0] ps,
  input  logic [NUM_ITEMS-1:0]           ps_load,
  input  logic [PS_W-1:0]                ps_wval,
  output logic [NUM_ITEMS-1:0]           item_q,
  output logic                           accept_q,
  output logic                           valid_q,
  output logic [INDEX_W-1:0]             index_q
);

  function automatic logic [PS_W-1:0] reload(input logic [PS_W-1:0] n);
    return (n == '0) ? '0 : n - PS_W'(1);
  endfunction

  function automatic logic [INDEX_W-1:0] first_set(input logic [NUM_ITEMS-1:0] v);
    logic [INDEX_W-1:0] r;
    r = '0;
    for (int i = NUM_ITEMS - 1; i >= 0; i--)
      if (v[i]) r = INDEX_W'(i);
    return r;
  endfunction

  function automatic logic bit_at(input logic [NUM_ITEMS-1:0] v, input logic [INDEX_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_ITEMS; i++)
      if (INDEX_W'(i) == idx) r = v[i];
    return r;
  endfunction

  function automatic logic below_clear(input logic [NUM_ITEMS-1:0] v, input logic [INDEX_W-1:0] idx);
    logic r;
    r = 1'b1;
    for (int i = 0; i < NUM_ITEMS; i++)
      if ((INDEX_W'(i) < idx) && v[i]) r = 1'b0;
    return r;
  endfunction

  logic [NUM_ITEMS-1:0] pass;

  for (genvar i = 0; i < NUM_ITEMS; i++) begin : g_ps
    logic [PS_W-1:0] cnt;
    logic            hit;
    logic            armed;

    assign hit     = match_q[i] & ~veto[i];
    assign armed   = (ps[i] != '0);
    assign pass[i] = hit & armed & (cnt == '0);

    always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (ps_load[i])    cnt <= reload(ps_wval);
      else if (hit && armed)  cnt <= (cnt == '0) ? reload(ps[i]) : cnt - PS_W'(1);
    end

    // R6: the counter stays inside the period of a non-zero prescale.
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      (ps[i] != '0) |-> (cnt < ps[i]));
    // R6: a zero prescale value never lets the item through.
    assert_zero_blocks_R6: assert property (@(posedge clk) disable iff (rst)
      (ps[i] == '0) |=> !item_q[i]);
    // R5: a vetoed item never survives.
    assert_veto_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      veto[i] |=> !item_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      item_q   <= '0;
      accept_q <= 1'b0;
      valid_q  <= 1'b0;
      index_q  <= '0;
    end else begin
      item_q   <= pass;
      accept_q <= |pass;
      valid_q  <= |pass;
      index_q  <= first_set(pass);
    end
  end

  // R7: a valid index names a surviving item with no lower survivor.
  assert_index_lowest_R7: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (bit_at(item_q, index_q) && below_clear(item_q, index_q)));
  // R7: no survivor means no valid flag and no accept.
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (item_q == '0) |-> (!valid_q && !accept_q));

endmodule

// File: rtl/trig_menu.sv
module trig_menu
  import tmenu_pkg::*;
#(
  parameter int unsigned NUM_FIELDS     = 4,
  parameter int unsigned COND_PER_FIELD = 4,
  parameter int unsigned NUM_ITEMS      = 16,
  parameter int unsigned PS_W           = 8,
  parameter int unsigned CFG_W          = 16,
  localparam int unsigned NC            = NUM_FIELDS * COND_PER_FIELD,
  localparam int unsigned TW            = NUM_FIELDS * CNT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TW-1:0]        trig_in,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [7:0]           cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [NUM_ITEMS-1:0] item_pass,
  output logic                 accept,
  output logic                 first_valid,
  output logic [INDEX_W-1:0]   first_index
);

  logic [NUM_FIELDS-1:0][LUT_D-1:0][COND_PER_FIELD-1:0] lut;
  logic [NUM_ITEMS-1:0][NC-1:0]   req;
  logic [NUM_ITEMS-1:0][NC-1:0]   care;
  logic [NUM_ITEMS-1:0]           veto;
  logic [NUM_ITEMS-1:0][PS_W-1:0] ps;
  logic [NUM_ITEMS-1:0]           ps_load;
  logic [PS_W-1:0]                ps_wval;
  logic [NC-1:0]                  cond_q;
  logic [NUM_ITEMS-1:0]           match_q;

  tmenu_cfg #(
    .NUM_FIELDS(NUM_FIELDS), .COND_PER_FIELD(COND_PER_FIELD),
    .NUM_ITEMS(NUM_ITEMS), .PS_W(PS_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .lut(lut), .req(req), .care(care),
    .veto(veto), .ps(ps), .ps_load(ps_load), .ps_wval(ps_wval)
  );

  tmenu_decode #(
    .NUM_FIELDS(NUM_FIELDS), .COND_PER_FIELD(COND_PER_FIELD)
  ) u_decode (
    .clk(clk), .rst(rst), .trig_in(trig_in), .lut(lut), .cond_q(cond_q)
  );

  tmenu_match #(
    .NC(NC), .NUM_ITEMS(NUM_ITEMS)
  ) u_match (
    .clk(clk), .rst(rst), .cond_q(cond_q), .req(req), .care(care), .match_q(match_q)
  );

  tmenu_select #(
    .NUM_ITEMS(NUM_ITEMS), .PS_W(PS_W)
  ) u_select (
    .clk(clk), .rst(rst), .match_q(match_q), .veto(veto), .ps(ps),
    .ps_load(ps_load), .ps_wval(ps_wval), .item_q(item_pass), .accept_q(accept),
    .valid_q(first_valid), .index_q(first_index)
  );

  // R8: nothing reaches the outputs in the first cycle out of reset.
  assert_pipe_empty_R8: assert property (@(posedge clk)
    $fell(rst) |-> (item_pass == '0 && !accept));

endmodule

// File: tb/sim_trig_menu.sv
`timescale 1ns/1ps
module sim_trig_menu;
  localparam int NF  = 4;
  localparam int CPF = 4;
  localparam int NI  = 16;
  localparam int NC  = NF * CPF;
  localparam int TW  = NF * 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] trig_in = '0;
  logic cfg_en = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [NI-1:0] item_pass;
  logic accept, first_valid;
  logic [7:0] first_index;

  always #4 clk = ~clk;

  trig_menu u0 (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .item_pass(item_pass), .accept(accept), .first_valid(first_valid),
    .first_index(first_index)
  );

  // Reference model state
  int lut_m [NF][8];
  logic [NC-1:0] req_m [NI];
  logic [NC-1:0] care_m [NI];
  logic [NI-1:0] veto_m;
  int ps_m [NI];
  int cnt_m [NI];
  logic [NC-1:0] c1;
  logic [NI-1:0] m2;
  logic [NI-1:0] e_items;
  int e_idx;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R1";

  task automatic model_reset();
    for (int f = 0; f < NF; f++)
      for (int c = 0; c < 8; c++) begin
        lut_m[f][c] = 0;
        for (int k = 0; k < CPF; k++) if (c > k) lut_m[f][c] |= (1 << k);
      end
    for (int i = 0; i < NI; i++) begin
      req_m[i] = '0; care_m[i] = '0; ps_m[i] = 1; cnt_m[i] = 0;
    end
    veto_m = '0; c1 = '0; m2 = '0; e_items = '0; e_idx = 0;
  endtask

  // Advance the model by one crossing, in the order the stages are defined.
  task automatic model_step();
    logic [NI-1:0] pass;
    logic [NI-1:0] nm;
    logic [NC-1:0] nc;
    pass = '0;
    for (int i = 0; i < NI; i++)
      if (m2[i] && !veto_m[i] && ps_m[i] != 0) begin
        if (cnt_m[i] == 0) begin pass[i] = 1'b1; cnt_m[i] = ps_m[i] - 1; end
        else cnt_m[i] = cnt_m[i] - 1;
      end
    for (int i = 0; i < NI; i++)
      nm[i] = (care_m[i] != 0) && ((c1 & care_m[i]) == (req_m[i] & care_m[i]));
    for (int f = 0; f < NF; f++)
      nc[f*CPF +: CPF] = CPF'(lut_m[f][int'(trig_in[f*3 +: 3])]);
    e_items = pass;
    e_idx = 0;
    for (int i = NI - 1; i >= 0; i--) if (pass[i]) e_idx = i;
    m2 = nm;
    c1 = nc;
    if (cfg_en && cfg_we) begin
      case (cfg_sel)
        3'd0: if (int'(cfg_addr[7:3]) < NF) lut_m[cfg_addr[7:3]][cfg_addr[2:0]] = int'(cfg_wdata[CPF-1:0]);
        3'd1: if (int'(cfg_addr) < NI) req_m[cfg_addr] = cfg_wdata[NC-1:0];
        3'd2: if (int'(cfg_addr) < NI) care_m[cfg_addr] = cfg_wdata[NC-1:0];
        3'd3: veto_m = cfg_wdata[NI-1:0];
        3'd4: if (int'(cfg_addr) < NI) begin
                ps_m[cfg_addr] = int'(cfg_wdata[7:0]);
                cnt_m[cfg_addr] = (ps_m[cfg_addr] == 0) ? 0 : ps_m[cfg_addr] - 1;
              end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    logic ev;
    ev = (e_items != '0);
    vectors++;
    if (item_pass !== e_items) begin
      miscompares++;
      $display("FAIL %s item_pass act=%h exp=%h t=%0t", tag, item_pass, e_items, $time);
    end else if (accept !== ev || first_valid !== ev) begin
      miscompares++;
      $display("FAIL %s accept/valid act=%b/%b exp=%b t=%0t", tag, accept, first_valid, ev, $time);
    end else if (ev && int'(first_index) != e_idx) begin
      miscompares++;
      $display("FAIL %s first_index act=%0d exp=%0d t=%0t", tag, first_index, e_idx, $time);
    end
  endtask

  // Drive one crossing at the falling edge, step the model, check after the next edge.
  task automatic cycle(input logic [TW-1:0] t, input logic en, input logic we,
                       input logic [2:0] s, input logic [7:0] a, input logic [15:0] d);
    trig_in = t; cfg_en = en; cfg_we = we; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] a, input logic [15:0] d);
    cycle(TW'($urandom), 1'b1, 1'b1, s, a, d);
  endtask

  task automatic idle(input int n, input logic [TW-1:0] t);
    for (int k = 0; k < n; k++) cycle(t, 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset contents; nothing can pass with empty care masks
    tag = "R1";
    for (int k = 0; k < 8; k++) cycle(TW'($urandom), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    // R2 / R3: default threshold decode and masked match
    tag = "R3";
    wr(3'd1, 8'd0, 16'h0002); wr(3'd2, 8'd0, 16'h0002);   // field0 count >= 2
    wr(3'd1, 8'd3, 16'h0010); wr(3'd2, 8'd3, 16'h0030);   // field1 count == 1
    wr(3'd1, 8'd7, 16'h0001); wr(3'd2, 8'd7, 16'h0001);   // field0 count >= 1
    tag = "R2";
    for (int c = 0; c < 8; c++) cycle(TW'({3'd0, 3'd0, 3'(c % 3), 3'(c)}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    idle(3, '0);
    // R7: overlapping items, lowest index reported
    tag = "R7";
    for (int c = 0; c < 8; c++) cycle(TW'({3'd0, 3'd0, 3'd1, 3'(c)}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    idle(3, '0);
    // R5: veto item 0
    tag = "R5";
    wr(3'd3, 8'd0, 16'h0001);
    for (int c = 0; c < 6; c++) cycle(TW'({3'd0, 3'd0, 3'd1, 3'(c + 2)}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    wr(3'd3, 8'd0, 16'h0000);
    // R6: prescale 3 on item 7, prescale 0 on item 3
    tag = "R6";
    wr(3'd4, 8'd7, 16'd3);
    wr(3'd4, 8'd3, 16'd0);
    for (int k = 0; k < 14; k++) cycle(TW'({3'd0, 3'd0, 3'd1, 3'd1}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    wr(3'd4, 8'd7, 16'd1);
    idle(3, TW'({3'd0, 3'd0, 3'd1, 3'd1}));
    // R10: reprogram field2 table so only count 5 drives condition 11
    tag = "R10";
    for (int c = 0; c < 8; c++) wr(3'd0, 8'((2 << 3) | c), (c == 5) ? 16'h0008 : 16'h0000);
    wr(3'd1, 8'd9, 16'h0800); wr(3'd2, 8'd9, 16'h0800);
    for (int c = 0; c < 8; c++) cycle(TW'({3'd0, 3'(c), 3'd0, 3'd0}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    // R9: writes without cfg_en are ignored
    tag = "R9";
    cycle('0, 1'b0, 1'b1, 3'd2, 8'd9, 16'h0000);
    cycle('0, 1'b0, 1'b1, 3'd3, 8'd0, 16'hFFFF);
    for (int k = 0; k < 4; k++) cycle(TW'({3'd0, 3'd5, 3'd0, 3'd3}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    // R8: a single matching crossing amid idle ones
    tag = "R8";
    idle(4, '0);
    cycle(TW'({3'd0, 3'd5, 3'd0, 3'd0}), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    idle(5, '0);
    // R4: required pattern set but care mask zero
    tag = "R4";
    wr(3'd1, 8'd10, 16'hFFFF);
    for (int k = 0; k < 6; k++) cycle(TW'($urandom), 1'b0, 1'b0, 3'd0, 8'd0, 16'd0);
    // R3: random traffic with interleaved configuration
    tag = "R3";
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] s;
      logic [15:0] d;
      s = 3'($urandom_range(0, 4));
      d = 16'($urandom);
      if (s == 3'd2 || s == 3'd3) d = d & 16'($urandom) & 16'($urandom);
      if (s == 3'd4) d = 16'($urandom_range(0, 4));
      cycle(TW'($urandom), ($urandom_range(0, 9) < 2), 1'($urandom), s,
            (s == 3'd0) ? 8'($urandom_range(0, 39)) : 8'($urandom_range(0, 19)), d);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule